// File: doc/BRIEF.md
# Receive Packet Qualifier

This block sits behind the bit-level demodulator of a packet radio receiver and works on a stream of whole bytes. It looks for a run of preamble bytes and then for the sync word. After the sync word it reads the packet body, which is either a length-prefixed payload or a fixed-size payload, and it can check a trailing CRC byte. Only payload that passes the chosen qualification is committed to a byte-wide packet memory. The memory itself lies outside the block.

The block drives the memory through a write port. Payload bytes land at the next free address past the packets already committed. A packet-valid pulse commits them and moves the free pointer forward by the packet length. A packet that fails its CRC leaves the pointer where it was, so the next packet overwrites the rejected bytes. Each packet starts with a search for the sync word. Two frame profiles are built in. A select input picks one of them, and the block samples it when the sync word is found.

Top module: `rx_pkt_qualifier`

## Requirements
- R1: With `qual_pre` high, the sync word is accepted only after at least PRE_LEN consecutive bytes of value 0x55. A shorter run followed by the sync word yields no packet.
- R2: After the preamble, the sync word must complete by the SYNC_TIMEOUT-th (default 8) byte that is not 0x55. Otherwise the block returns to preamble search, and the late sync word yields no packet.
- R3: With `qual_pre` low, the sync word alone starts a packet, with no preamble before it.
- R4: In a length-prefixed profile, the first byte after the sync word gives the payload length N. Payload byte i is written with `ram_we` high at address base+i, and a length of 0 writes nothing.
- R5: In a fixed-size profile, the payload is exactly the profile's configured number of bytes, and no length byte is read.
- R6: `prof_sel` is sampled on the byte that completes the sync word. A later change of `prof_sel` has no effect on the packet in progress.
- R7: The CRC is CRC-8 with polynomial 0x07 and initial value 0x00, taken MSB-first over the length byte (when present) and the payload. When the CRC matches, `pkt_valid` pulses for one cycle. `rx_len` then shows N, `pkt_base` shows the packet's start address, and the next packet starts at base+N.
- R8: With `qual_crc` high, a CRC mismatch pulses `crc_err`, raises no `pkt_valid`, leaves `pkt_base` and `rx_len` unchanged, and makes the next packet start at the same base.
- R9: With `qual_crc` low, the CRC byte is consumed and the packet is accepted whatever its value.
- R10: In a profile with CRC, a length byte above 254 aborts the packet. The block then writes nothing, raises no event and returns to search.
- R11: After every packet, whether committed, failed or aborted, the block returns to search. With `qual_pre` high, a new preamble is needed again.
- R12: During and right after reset, `ram_we`, `pkt_valid` and `crc_err` are low, and `rx_len`, `pkt_base` and the free pointer are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| prof_sel | input | 1 | Frame profile select (0 or 1) |
| qual_pre | input | 1 | Require preamble before sync |
| qual_crc | input | 1 | Reject packets whose CRC mismatches |
| ram_we | output | 1 | Packet memory write enable |
| ram_addr | output | AW | Packet memory write address |
| ram_wdata | output | 8 | Packet memory write data |
| pkt_valid | output | 1 | One-cycle pulse: packet committed |
| crc_err | output | 1 | One-cycle pulse: CRC mismatch |
| rx_len | output | 8 | Payload length of last committed packet |
| pkt_base | output | AW | Start address of last committed packet |

## Verification
The bench builds the block with its default parameters. Those are a three-byte preamble, sync word 0xD391, a timeout of eight bytes, profile 0 with a length byte and CRC, and profile 1 with a fixed four-byte payload and no CRC. With these values the timeout boundary can be reached in a few bytes, on both sides: six filler bytes before the sync word pass and seven fail. Both profiles can be exercised in one run. A 256-entry memory lets the rollback after a CRC failure be seen as an overwrite at an unchanged address.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {ST_SRCH, ST_LEN, ST_DATA, ST_CRC} rxq_state_t;

  function automatic logic [7:0] crc8_next(input logic [7:0] c, input logic [7:0] b,
                                           input logic [7:0] poly);
    logic [7:0] r;
    r = c ^ b;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ poly) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/rxq_sync_hunter.sv
module rxq_sync_hunter #(
  parameter int          PRE_LEN      = 3,
  parameter int          SYNC_BYTES   = 2,
  parameter logic [SYNC_BYTES*8-1:0] SYNC_WORD = 16'hD391,
  parameter int          SYNC_TIMEOUT = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       need_pre,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       hit
);
  localparam int SHW = (SYNC_BYTES - 1) * 8;
  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam int TCW = $clog2(SYNC_TIMEOUT + 1);

  logic [SHW-1:0] shreg;
  logic [PCW-1:0] pre_cnt;
  logic [TCW-1:0] to_cnt;
  logic           armed;

  assign hit = active && in_valid && (armed || !need_pre) && ({shreg, in_byte} == SYNC_WORD);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      shreg   <= '0;
      pre_cnt <= '0;
      to_cnt  <= '0;
      armed   <= 1'b0;
    end else if (in_valid) begin
      shreg <= {shreg, in_byte} >> 0;
      if (!armed) begin
        if (in_byte == 8'h55) begin
          if (pre_cnt == PCW'(PRE_LEN - 1)) begin
            armed  <= 1'b1;
            to_cnt <= '0;
          end else begin
            pre_cnt <= pre_cnt + 1'b1;
          end
        end else begin
          pre_cnt <= '0;
        end
      end else if (need_pre && !hit && in_byte != 8'h55) begin
        if (to_cnt == TCW'(SYNC_TIMEOUT - 1)) begin
          armed   <= 1'b0;
          pre_cnt <= '0;
        end else begin
          to_cnt <= to_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxq_crc8.sv
module rxq_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import rxq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= 8'h00;
    else if (upd)   crc <= crc8_next(crc, din, POLY);
  end
endmodule

// File: rtl/rxq_frame_ctrl.sv
module rxq_frame_ctrl #(
  parameter int         AW     = 8,
  parameter logic       P0_VAR = 1'b1,
  parameter logic       P0_CRC = 1'b1,
  parameter logic [7:0] P0_LEN = 8'd0,
  parameter logic       P1_VAR = 1'b0,
  parameter logic       P1_CRC = 1'b0,
  parameter logic [7:0] P1_LEN = 8'd4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          sync_hit,
  input  logic          prof_sel,
  input  logic          qual_crc,
  input  logic [7:0]    crc_val,
  output logic          searching,
  output logic          crc_clr,
  output logic          crc_upd,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          pkt_valid,
  output logic          crc_err,
  output logic [7:0]    rx_len,
  output logic [AW-1:0] pkt_base
);
  import rxq_pkg::*;

  localparam logic [7:0] MAX_LEN_CRC = 8'd254;

  rxq_state_t    st, nxt;
  logic          crc_on_q;
  logic [7:0]    len_q, idx_q;
  logic [AW-1:0] base_q;

  logic       p_var, p_crc, crc_flag;
  logic [7:0] p_len, body_len, commit_len, max_len;
  logic       start_body, do_commit, do_err, do_wr;

  assign p_var    = prof_sel ? P1_VAR : P0_VAR;
  assign p_crc    = prof_sel ? P1_CRC : P0_CRC;
  assign p_len    = prof_sel ? P1_LEN : P0_LEN;
  assign crc_flag = (st == ST_SRCH) ? p_crc : crc_on_q;
  assign max_len  = crc_on_q ? MAX_LEN_CRC : 8'hFF;
  assign searching = (st == ST_SRCH);

  always_comb begin
    nxt = st; start_body = 1'b0; body_len = 8'd0;
    do_commit = 1'b0; do_err = 1'b0; do_wr = 1'b0;
    commit_len = len_q; crc_clr = 1'b0; crc_upd = 1'b0;
    if (in_valid) begin
      case (st)
        ST_SRCH: if (sync_hit) begin
          crc_clr = 1'b1;
          if (p_var) nxt = ST_LEN;
          else begin start_body = 1'b1; body_len = p_len; end
        end
        ST_LEN: begin
          crc_upd = 1'b1;
          if (in_byte > max_len) nxt = ST_SRCH;
          else begin start_body = 1'b1; body_len = in_byte; end
        end
        ST_DATA: begin
          crc_upd = 1'b1;
          do_wr   = 1'b1;
          if (idx_q == len_q - 8'd1) begin
            if (crc_on_q) nxt = ST_CRC;
            else do_commit = 1'b1;
          end
        end
        default: begin
          if (in_byte == crc_val || !qual_crc) do_commit = 1'b1;
          else do_err = 1'b1;
          nxt = ST_SRCH;
        end
      endcase
      if (start_body) begin
        if (body_len != 8'd0) nxt = ST_DATA;
        else if (crc_flag)    nxt = ST_CRC;
        else begin do_commit = 1'b1; commit_len = 8'd0; end
      end
      if (do_commit) nxt = ST_SRCH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_SRCH; crc_on_q <= 1'b0; len_q <= '0; idx_q <= '0; base_q <= '0;
      ram_we <= 1'b0; ram_addr <= '0; ram_wdata <= '0;
      pkt_valid <= 1'b0; crc_err <= 1'b0; rx_len <= '0; pkt_base <= '0;
    end else begin
      st        <= nxt;
      ram_we    <= do_wr;
      pkt_valid <= do_commit;
      crc_err   <= do_err;
      if (in_valid && st == ST_SRCH && sync_hit) begin
        crc_on_q <= p_crc;
        idx_q    <= '0;
      end
      if (start_body) len_q <= body_len;
      if (do_wr) begin
        ram_addr  <= base_q + AW'(idx_q);
        ram_wdata <= in_byte;
        idx_q     <= idx_q + 8'd1;
      end
      if (do_commit) begin
        rx_len   <= commit_len;
        pkt_base <= base_q;
        base_q   <= base_q + AW'(commit_len);
      end
    end
  end
endmodule

// File: rtl/rx_pkt_qualifier.sv
module rx_pkt_qualifier #(
  parameter int          AW           = 8,
  parameter int          PRE_LEN      = 3,
  parameter int          SYNC_BYTES   = 2,
  parameter logic [SYNC_BYTES*8-1:0] SYNC_WORD = 16'hD391,
  parameter int          SYNC_TIMEOUT = 8,
  parameter logic [7:0]  CRC_POLY     = 8'h07,
  parameter logic        P0_VAR       = 1'b1,
  parameter logic        P0_CRC       = 1'b1,
  parameter logic [7:0]  P0_LEN       = 8'd0,
  parameter logic        P1_VAR       = 1'b0,
  parameter logic        P1_CRC       = 1'b0,
  parameter logic [7:0]  P1_LEN       = 8'd4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          prof_sel,
  input  logic          qual_pre,
  input  logic          qual_crc,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          pkt_valid,
  output logic          crc_err,
  output logic [7:0]    rx_len,
  output logic [AW-1:0] pkt_base
);
  logic       searching, sync_hit, crc_clr, crc_upd;
  logic [7:0] crc_val;

  rxq_sync_hunter #(
    .PRE_LEN(PRE_LEN), .SYNC_BYTES(SYNC_BYTES), .SYNC_WORD(SYNC_WORD),
    .SYNC_TIMEOUT(SYNC_TIMEOUT)
  ) i_hunter (
    .clk(clk), .rst(rst), .active(searching), .need_pre(qual_pre),
    .in_valid(in_valid), .in_byte(in_byte), .hit(sync_hit)
  );

  rxq_crc8 #(.POLY(CRC_POLY)) i_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .upd(crc_upd), .din(in_byte), .crc(crc_val)
  );

  rxq_frame_ctrl #(
    .AW(AW), .P0_VAR(P0_VAR), .P0_CRC(P0_CRC), .P0_LEN(P0_LEN),
    .P1_VAR(P1_VAR), .P1_CRC(P1_CRC), .P1_LEN(P1_LEN)
  ) i_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .sync_hit(sync_hit), .prof_sel(prof_sel), .qual_crc(qual_crc), .crc_val(crc_val),
    .searching(searching), .crc_clr(crc_clr), .crc_upd(crc_upd),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .pkt_valid(pkt_valid), .crc_err(crc_err), .rx_len(rx_len), .pkt_base(pkt_base)
  );
endmodule

// File: rtl/rx_pkt_qualifier_chk.sv
module rx_pkt_qualifier_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic          pkt_valid,
  input logic          crc_err,
  input logic [7:0]    rx_len,
  input logic [AW-1:0] pkt_base
);
  // R8
  no_dual_evt_chk: assert property (@(posedge clk) disable iff (rst) !(pkt_valid && crc_err));
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst) pkt_valid |=> !pkt_valid);
  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst) crc_err |=> !crc_err);
  // R7
  base_move_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_base != $past(pkt_base)) |-> pkt_valid);
  // R4
  len_move_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_len != $past(rx_len)) |-> pkt_valid);
  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> (pkt_base == $past(pkt_base) && rx_len == $past(rx_len)));
  // R4
  addr_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |-> ram_addr == $past(ram_addr) + 1'b1);
endmodule

bind rx_pkt_qualifier rx_pkt_qualifier_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .ram_we(ram_we), .ram_addr(ram_addr), .pkt_valid(pkt_valid),
  .crc_err(crc_err), .rx_len(rx_len), .pkt_base(pkt_base)
);

// File: tb/test_rx_pkt_qualifier.sv
module test_rx_pkt_qualifier;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, prof_sel = 1'b0;
  logic qual_pre = 1'b1, qual_crc = 1'b1;
  logic [7:0] in_byte = 8'h00;
  logic ram_we, pkt_valid, crc_err;
  logic [7:0] ram_addr, ram_wdata, rx_len, pkt_base;

  int n_run = 0, n_fail = 0, n_wr = 0, n_ok = 0, n_err = 0;
  logic [7:0] mem [256];
  bit flip_prof = 0;

  rx_pkt_qualifier i_rx_pkt_qualifier (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .prof_sel(prof_sel),
    .qual_pre(qual_pre), .qual_crc(qual_crc), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .pkt_valid(pkt_valid), .crc_err(crc_err), .rx_len(rx_len),
    .pkt_base(pkt_base)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (!rst) begin
    if (ram_we) begin mem[ram_addr] = ram_wdata; n_wr++; end
    if (pkt_valid) n_ok++;
    if (crc_err) n_err++;
  end

  function automatic logic [7:0] crc_of(input logic [7:0] acc, input logic [7:0] b);
    logic [7:0] v = acc;
    for (int j = 7; j >= 0; j--) begin
      logic fb = v[7] ^ b[j];
      v = {v[6:0], 1'b0};
      if (fb) v = v ^ 8'h07;
    end
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_byte = b;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic preamble(input int n);
    for (int i = 0; i < n; i++) send(8'h55);
  endtask

  task automatic sync();
    send(8'hD3); send(8'h91);
  endtask

  // length-prefixed body with CRC; payload bytes are seed+i
  task automatic var_body(input int n, input logic [7:0] seed, input bit bad);
    logic [7:0] c = crc_of(8'h00, 8'(n));
    send(8'(n));
    if (flip_prof) prof_sel = 1'b1;
    for (int i = 0; i < n; i++) begin
      c = crc_of(c, seed + 8'(i));
      send(seed + 8'(i));
    end
    send(bad ? ~c : c);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R12 ram_we", ram_we, 0); check("R12 pkt_valid", pkt_valid, 0);
    check("R12 crc_err", crc_err, 0); check("R12 rx_len", rx_len, 0);
    check("R12 pkt_base", pkt_base, 0);
  endtask

  task automatic t_var_ok();
    int ok0 = n_ok;
    prof_sel = 0; qual_pre = 1; qual_crc = 1; flip_prof = 1;
    preamble(3); sync(); var_body(3, 8'hA1, 0);
    flip_prof = 0; prof_sel = 0;
    check("R7 valid", n_ok - ok0, 1); check("R4 rx_len", rx_len, 3);
    check("R7 pkt_base", pkt_base, 0);
    check("R4 mem0", mem[0], 8'hA1); check("R4 mem2", mem[2], 8'hA3);
    check("R6 profile latched", n_wr, 3);
  endtask

  task automatic t_crc_bad();
    int ok0 = n_ok, e0 = n_err;
    preamble(3); sync(); var_body(2, 8'hB1, 1);
    check("R8 crc_err", n_err - e0, 1); check("R8 no valid", n_ok - ok0, 0);
    check("R8 base kept", pkt_base, 0); check("R8 len kept", rx_len, 3);
    preamble(3); sync(); var_body(2, 8'hC1, 0);
    check("R8 rollback base", pkt_base, 3); check("R8 overwrite", mem[3], 8'hC1);
  endtask

  task automatic t_crc_off();
    int ok0 = n_ok, e0 = n_err;
    qual_crc = 0;
    preamble(3); sync(); var_body(1, 8'hD1, 1);
    qual_crc = 1;
    check("R9 accepted", n_ok - ok0, 1); check("R9 no err", n_err - e0, 0);
    check("R9 base", pkt_base, 5);
  endtask

  task automatic t_fixed();
    int ok0 = n_ok;
    prof_sel = 1;
    preamble(3); sync();
    for (int i = 0; i < 4; i++) send(8'hE1 + 8'(i));
    repeat (2) @(negedge clk);
    prof_sel = 0;
    check("R5 valid", n_ok - ok0, 1); check("R5 rx_len", rx_len, 4);
    check("R5 base", pkt_base, 6); check("R5 last", mem[9], 8'hE4);
  endtask

  task automatic t_toolong();
    int ok0 = n_ok, e0 = n_err, w0 = n_wr;
    preamble(3); sync(); send(8'hFF);
    for (int i = 0; i < 4; i++) send(8'h10);
    repeat (2) @(negedge clk);
    check("R10 no valid", n_ok - ok0, 0); check("R10 no err", n_err - e0, 0);
    check("R10 no write", n_wr - w0, 0);
    preamble(3); sync(); var_body(1, 8'hF1, 0);
    check("R10 search again", pkt_base, 10);
  endtask

  task automatic t_pre_short();
    int ok0 = n_ok;
    preamble(2); sync(); var_body(1, 8'h21, 0);
    check("R1 short preamble", n_ok - ok0, 0);
  endtask

  task automatic t_timeout();
    int ok0 = n_ok;
    preamble(3); repeat (6) send(8'h00); sync(); var_body(1, 8'h31, 0);
    check("R2 sync in window", n_ok - ok0, 1); check("R2 base", pkt_base, 11);
    preamble(3); repeat (7) send(8'h00); sync(); var_body(1, 8'h41, 0);
    check("R2 sync late", n_ok - ok0, 1);
  endtask

  task automatic t_nopre();
    int ok0 = n_ok;
    qual_pre = 0;
    send(8'h00); sync(); var_body(1, 8'h51, 0);
    qual_pre = 1;
    check("R3 sync only", n_ok - ok0, 1); check("R3 base", pkt_base, 12);
  endtask

  task automatic t_len0();
    int ok0 = n_ok, w0 = n_wr;
    preamble(3); sync(); var_body(0, 8'h00, 0);
    check("R4 len0 valid", n_ok - ok0, 1); check("R4 len0 rx_len", rx_len, 0);
    check("R4 len0 no write", n_wr - w0, 0); check("R7 len0 base", pkt_base, 13);
  endtask

  task automatic t_rearm();
    int ok0 = n_ok;
    preamble(3); sync(); var_body(1, 8'h61, 0);
    sync(); var_body(1, 8'h71, 0);
    check("R11 rearm", n_ok - ok0, 1);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_var_ok();
    t_crc_bad();
    t_crc_off();
    t_fixed();
    t_toolong();
    t_pre_short();
    t_timeout();
    t_nopre();
    t_len0();
    t_rearm();
    report();
  end
endmodule